// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one 32-pin general-purpose I/O port. Software drives pins through an output data register and an output-enable register. It reads the pins back through an input data register, which is fed by a two-flop synchroniser on the pad inputs. Any pin can also serve as an interrupt source. Its detection mode is either edge or level, and its active sense is either low/falling or high/rising. Each pin latches its events into a sticky status register, and a single combined interrupt line goes to the system interrupt controller.

Every writable register has three addresses:

- a direct address, which replaces the whole register;
- a set alias, which ORs in the bits that are 1 in the written mask;
- a clear alias, which removes the bits that are 1 in the written mask.

Because of the aliases, software can change one pin without a read-modify-write. The status register can only be cleared, and only through its clear alias. The usual driver sequence is:

1. Pick the interrupt type through the mode and sense registers.
2. Clear the pin's stale status.
3. Enable the pin.
4. On an interrupt, read status AND enable.
5. Acknowledge each serviced pin through the status clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: The register base offsets are: output data 0x00, input data 0x10, output enable 0x20, interrupt select 0x30, interrupt enable 0x40, mode 0x50, sense 0x60, status 0x70. A write to base+0x0 replaces a writable register. A read of any of the register's three addresses returns its value, in the same cycle. Unmapped addresses read 0.
- R3: A write to base+0x4 sets the register bits that are 1 in `wdata`. A write to base+0x8 clears the register bits that are 1 in `wdata`. All other bits keep their values.
- R4: `pad_out` equals the output data register and `pad_oe` equals the output-enable register. Bit n controls pin n.
- R5: The input data register returns `pad_in` delayed by the two synchroniser flops. Writes to it have no effect.
- R6: A pin's interrupt type is set by its mode bit (1 = level) and its sense bit (1 = high/rising). Edge mode with sense 1 sets status on a 0→1 transition of the synchronised pin. Edge mode with sense 0 sets status on a 1→0 transition. No other transition sets status.
- R7: In level mode, status is set on every cycle the pin sits at its active level (high for sense 1, low for sense 0). A clear issued while the level persists therefore leaves the bit at 1.
- R8: A status bit can be set only while the pin's interrupt select bit is 1.
- R9: Status bits are cleared only by writing ones to 0x78. Direct writes and set-alias writes to status have no effect.
- R10: If a detection event and a clear hit the same status bit in the same cycle, the bit ends at 1.
- R11: `irq` is 1 exactly when the bitwise AND of status and interrupt enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data or bit mask |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin; 0 means high-impedance |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench targets three subtle status behaviours:

- **Level pin cleared while still active.** A design that let the clear win would drop the bit and lose the request. The bench checks that the bit reads 1 right after the clear.
- **Edge of the wrong direction.** A design that detected any change instead of the configured transition would flag it. The bench checks that no bit is set.
- **Status writes outside the clear alias.** Direct writes and set-alias writes must not reach status. A design that treated status like the other registers would raise interrupts from software writes.

The bench also checks that a pin with its select bit at 0 never sets status, whatever its mode. It checks that `irq` follows both enable and status in each direction, and that a set or clear alias write touches only the masked bits.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam logic [AW-5:0] IDX_DOUT = 'd0;
  localparam logic [AW-5:0] IDX_DIN  = 'd1;
  localparam logic [AW-5:0] IDX_OE   = 'd2;
  localparam logic [AW-5:0] IDX_SEL  = 'd3;
  localparam logic [AW-5:0] IDX_EN   = 'd4;
  localparam logic [AW-5:0] IDX_MODE = 'd5;
  localparam logic [AW-5:0] IDX_SNS  = 'd6;
  localparam logic [AW-5:0] IDX_STAT = 'd7;

  logic [AW-5:0] idx;
  logic [3:0]    sub;
  logic          op_wr, op_set, op_clr;

  assign idx    = addr[AW-1:4];
  assign sub    = addr[3:0];
  assign op_wr  = wr_en && (sub == 4'h0);
  assign op_set = wr_en && (sub == 4'h4);
  assign op_clr = wr_en && (sub == 4'h8);

  logic [NPINS-1:0] dout_q, oe_q, sel_q, en_q, mode_q, sns_q, stat_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;

  function automatic logic [NPINS-1:0] upd(input logic [NPINS-1:0] cur);
    if (op_wr)       upd = wdata;
    else if (op_set) upd = cur | wdata;
    else if (op_clr) upd = cur & ~wdata;
    else             upd = cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      sel_q  <= '0;
      en_q   <= '0;
      mode_q <= '0;
      sns_q  <= '0;
    end else begin
      if (idx == IDX_DOUT) dout_q <= upd(dout_q);
      if (idx == IDX_OE)   oe_q   <= upd(oe_q);
      if (idx == IDX_SEL)  sel_q  <= upd(sel_q);
      if (idx == IDX_EN)   en_q   <= upd(en_q);
      if (idx == IDX_MODE) mode_q <= upd(mode_q);
      if (idx == IDX_SNS)  sns_q  <= upd(sns_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  logic [NPINS-1:0] rise, fall, lvl_hit, edge_hit, hit, stat_clr;

  assign rise     = sync2_q & ~prev_q;
  assign fall     = ~sync2_q & prev_q;
  assign edge_hit = (sns_q & rise) | (~sns_q & fall);
  assign lvl_hit  = ~(sync2_q ^ sns_q);
  assign hit      = sel_q & ((mode_q & lvl_hit) | (~mode_q & edge_hit));
  assign stat_clr = (op_clr && idx == IDX_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | hit;
  end

  always_comb begin
    case (idx)
      IDX_DOUT: rdata = dout_q;
      IDX_DIN:  rdata = sync2_q;
      IDX_OE:   rdata = oe_q;
      IDX_SEL:  rdata = sel_q;
      IDX_EN:   rdata = en_q;
      IDX_MODE: rdata = mode_q;
      IDX_SNS:  rdata = sns_q;
      IDX_STAT: rdata = stat_q;
      default:  rdata = '0;
    endcase
  end

  assign pad_out = dout_q;
  assign pad_oe  = oe_q;
  assign irq     = |(stat_q & en_q);

  // A status bit only falls after a clear-alias write to status.
  assert_stat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_clr && idx == IDX_STAT) |=> ((~stat_q & $past(stat_q)) == '0));

  // A status bit only rises while its select bit was 1.
  assert_sel_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0));

  // After a set-alias write to output data, every masked bit is 1.
  assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_set && idx == IDX_DOUT) |=> ((pad_out & $past(wdata)) == $past(wdata)));

  // After a clear-alias write to output enable, every masked bit is 0.
  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_clr && idx == IDX_OE) |=> ((pad_oe & $past(wdata)) == '0));

  // An active level overrides a simultaneous clear.
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_q & mode_q & lvl_hit) != '0) |=> ((stat_q & $past(sel_q & mode_q & lvl_hit)) == $past(sel_q & mode_q & lvl_hit)));

  // The interrupt line never rises while enable is all zero.
  assert_irq_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));

endmodule

// File: tb/test_gpio_irq_port.sv
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_in, pad_out, pad_oe;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [7:0] A_DOUT = 8'h00, A_DIN = 8'h10, A_OE = 8'h20, A_SEL = 8'h30,
                         A_EN = 8'h40, A_MODE = 8'h50, A_SNS = 8'h60, A_STAT = 8'h70;
  localparam logic [7:0] SETO = 8'h4, CLRO = 8'h8;

  always #4 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    pad_in = '0; rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int r = 0; r < 8; r++) begin
      rd(8'(r * 16), v);
      check("R1 register reset", v, 32'h0);
    end
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 irq reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(A_DOUT, 32'hA5A5_0F0F);
    rd(A_DOUT, v); check("R2 direct write", v, 32'hA5A5_0F0F);
    rd(A_DOUT + SETO, v); check("R2 read via alias", v, 32'hA5A5_0F0F);
    rd(8'h90, v); check("R2 unmapped reads 0", v, 32'h0);
    wr(A_DOUT + SETO, 32'h0000_00F0);
    rd(A_DOUT, v); check("R3 set alias", v, 32'hA5A5_0FFF);
    wr(A_DOUT + CLRO, 32'hA000_000F);
    rd(A_DOUT, v); check("R3 clear alias", v, 32'h05A5_0FF0);
    wr(A_OE, 32'h0000_FFFF);
    idle(1);
    check("R4 pad_out", pad_out, 32'h05A5_0FF0);
    check("R4 pad_oe", pad_oe, 32'h0000_FFFF);
  endtask

  task automatic t_din();
    logic [31:0] v;
    do_reset();
    @(negedge clk); pad_in = 32'h1234_8765;
    idle(3);
    rd(A_DIN, v); check("R5 input data", v, 32'h1234_8765);
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, v); check("R5 input write ignored", v, 32'h1234_8765);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    do_reset();
    wr(A_SNS, 32'h0000_0008);
    wr(A_SEL, 32'h0000_0028);
    @(negedge clk); pad_in = 32'h0000_0020;
    idle(4);
    wr(A_STAT + CLRO, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R6 cleared before edges", v, 32'h0);
    @(negedge clk); pad_in = 32'h0000_0008;
    idle(4);
    rd(A_STAT, v); check("R6 rising on pin 3, falling on pin 5", v, 32'h0000_0028);
    wr(A_STAT + CLRO, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h0000_0020;
    idle(4);
    rd(A_STAT, v); check("R6 wrong-direction edges ignored", v, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    do_reset();
    wr(A_MODE, 32'h0000_0280);
    wr(A_SNS, 32'h0000_0080);
    @(negedge clk); pad_in = 32'h0000_0080;
    wr(A_SEL, 32'h0000_0280);
    idle(4);
    rd(A_STAT, v); check("R7 high and low levels", v, 32'h0000_0280);
    wr(A_STAT + CLRO, 32'h0000_0080);
    rd(A_STAT, v); check("R10 set beats clear while level active", v, 32'h0000_0280);
    @(negedge clk); pad_in = 32'h0000_0200;
    idle(4);
    wr(A_STAT + CLRO, 32'h0000_0280);
    rd(A_STAT, v); check("R7 clears once level inactive", v, 32'h0);
  endtask

  task automatic t_sel();
    logic [31:0] v;
    do_reset();
    wr(A_SNS, 32'h0000_0800);
    wr(A_MODE, 32'h0000_1000);
    @(negedge clk); pad_in = 32'h0000_0800;
    idle(6);
    rd(A_STAT, v); check("R8 unselected pins never set", v, 32'h0);
  endtask

  task automatic t_stat_wr();
    logic [31:0] v;
    do_reset();
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R9 direct write ignored", v, 32'h0);
    wr(A_STAT + SETO, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R9 set alias ignored", v, 32'h0);
    check("R9 no irq from status writes", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    do_reset();
    wr(A_SNS, 32'h0000_0004);
    wr(A_SEL, 32'h0000_0004);
    @(negedge clk); pad_in = 32'h0000_0004;
    idle(4);
    rd(A_STAT, v); check("R11 status latched", v, 32'h0000_0004);
    check("R11 irq low while disabled", {31'h0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0004);
    idle(1);
    check("R11 irq on enable", {31'h0, irq}, 32'h1);
    wr(A_EN + CLRO, 32'h0000_0004);
    idle(1);
    check("R11 irq off on disable", {31'h0, irq}, 32'h0);
    wr(A_EN + SETO, 32'h0000_0004);
    wr(A_STAT + CLRO, 32'h0000_0004);
    idle(1);
    check("R11 irq off after clear", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    pad_in = '0;
    t_reset();
    t_regs();
    t_din();
    t_edges();
    t_levels();
    t_sel();
    t_stat_wr();
    t_irq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule